// File: doc/BRIEF.md
# Microcoded CPU Control Sequencer

This block is the control unit and register datapath of a small 8-bit processor. A 32-bit microinstruction is read from a microcode store each clock cycle. Its fields drive the datapath controls, and a 2-bit next-address type tells the micro-PC what to do next. It can step to the next micro-address, return to the start of the instruction fetch routine, or dispatch to the microroutine of the opcode just fetched. Every transfer into the program counter or the memory address register goes through an adder. One operand comes from the PC or the memory data register and the other is a small immediate, so passing a value and incrementing it use the same path.

The microcode store holds two routines: a three-step instruction fetch at micro-address 0 and a three-step absolute jump at micro-address 27 (0x1B). The block presents a registered 8-bit address and a read strobe to a 256-byte memory space, where the lower half is ROM and the upper half is RAM. It captures read data at the end of the cycle that raises the strobe. The control word is registered, so it changes only on the rising clock edge and cannot glitch part way through a cycle. A program that bounces between an absolute jump at 0x00 and another at 0x80 must loop forever with a correct control word on every cycle.

Top module: `mcode_cpu_ctrl`

## Requirements
- R1: When the reset synchronizer releases, the micro-PC, PC and memory address are all 0, and the control word equals the first word of the fetch routine.
- R2: The control word layout is as follows. Bits [1:0] hold the next-address type. Bit 2 drives the PC onto the adder, bit 3 drives the MDR onto the adder, and bit 4 enables the immediate. Bits [8:5] hold the immediate value, bits [12:9] the ALU operation and bit 13 the ALU mode. Bits [15:14] hold the carry select. The write enables are bit 16 for MAR, bit 17 for PC, bit 18 for IR and bit 19 for MDR. Bit 20 selects memory data as the MDR input. Bit 21 is the read strobe. Bits [31:22] are zero.
- R3: The fetch routine occupies micro-addresses 0, 1 and 2. Step 0 loads MAR with the PC. Step 1 reads memory into IR. Step 2 writes the PC plus one back to the PC. No other step changes the PC.
- R4: The next-address type selects the following micro-address. Type 00 goes to the current micro-address plus one. Type 10 goes to micro-address 0. Type 11 dispatches on the IR opcode.
- R5: With ALU operation 1001 and mode 0, the adder adds the selected source, the immediate and a carry. Carry select 01 gives a carry of 0, so immediate 0 passes the source unchanged and immediate 1 increments it.
- R6: Opcode 0x20 dispatches to micro-address 27. Step 27 loads MAR with the PC. Step 28 reads memory into MDR through its memory-input select. Step 29 loads the PC from the MDR through the adder and returns to fetch.
- R7: Any opcode other than 0x20 dispatches to micro-address 0, so the next fetch uses the incremented PC.
- R8: The read strobe is high exactly in micro-steps 1 and 28. The data present on the read port in that cycle is the data captured.
- R9: The ROM select output is high for memory addresses 0x00 to 0x7F and the RAM select output is high for 0x80 to 0xFF, never both.
- R10: A program with an absolute jump to 0x80 at address 0x00 and an absolute jump to 0x00 at address 0x80 loops at least 100 times with every output correct on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rdata | input | 8 | Read data for the current memory address |
| mem_addr | output | 8 | Memory address (MAR contents) |
| mem_rd | output | 1 | Read strobe |
| rom_sel | output | 1 | Address lies in the ROM half |
| ram_sel | output | 1 | Address lies in the RAM half |
| pc | output | 8 | Program counter |
| upc | output | 5 | Current micro-address |
| ctrl_word | output | 32 | Registered control word of the current micro-step |

## Verification
Two functions share a cycle in this block. In fetch step 2, the PC increment and the opcode dispatch both take effect at the same edge. In jump step 29, the PC load from the MDR and the return to fetch coincide, so the very next MAR load must see the new PC. Back-to-back jumps between 0x00 and 0x80 provoke both collisions on every iteration. A second program of unknown opcodes followed by a jump provokes the dispatch-to-fetch case. A behavioural model of the routines judges the micro-address, PC, address, strobe, selects and full control word on every clock.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int DW    = 8;
  localparam int UA_W  = 5;
  localparam int IMM_W = 4;
  localparam int OP_W  = 4;

  typedef enum logic [1:0] {
    NX_STEP  = 2'b00,
    NX_RSV   = 2'b01,
    NX_FETCH = 2'b10,
    NX_DISP  = 2'b11
  } nxt_t;

  // packed MSB first: bit 31 down to bit 0
  typedef struct packed {
    logic [9:0]       spare;
    logic             rd;
    logic             mdr_sel;
    logic             mdr_we;
    logic             ir_we;
    logic             pc_we;
    logic             mar_we;
    logic [1:0]       cin;
    logic             mode;
    logic [OP_W-1:0]  op;
    logic [IMM_W-1:0] imm;
    logic             imm_oe;
    logic             mdr_oe;
    logic             pc_oe;
    nxt_t             nxt;
  } cw_t;

  localparam int CW_W = $bits(cw_t);

  localparam logic [OP_W-1:0] ALU_ADD  = 4'b1001;
  localparam logic [1:0]      CIN_ONE  = 2'b00;
  localparam logic [1:0]      CIN_ZERO = 2'b01;

  localparam logic [UA_W-1:0] UA_FETCH = '0;
  localparam logic [UA_W-1:0] UA_F1    = UA_FETCH + 1'b1;
  localparam logic [UA_W-1:0] UA_F2    = UA_FETCH + 2'd2;
  localparam logic [UA_W-1:0] UA_JMP   = 5'd27;
  localparam logic [UA_W-1:0] UA_J1    = UA_JMP + 1'b1;
  localparam logic [UA_W-1:0] UA_J2    = UA_JMP + 2'd2;

  function automatic cw_t ucode_word(logic [UA_W-1:0] a);
    cw_t w;
    w     = '0;
    w.nxt = NX_FETCH;
    case (a)
      UA_FETCH, UA_JMP: begin
        w.nxt    = NX_STEP;
        w.pc_oe  = 1'b1;
        w.imm_oe = 1'b1;
        w.op     = ALU_ADD;
        w.cin    = CIN_ZERO;
        w.mar_we = 1'b1;
      end
      UA_F1: begin
        w.nxt   = NX_STEP;
        w.rd    = 1'b1;
        w.ir_we = 1'b1;
      end
      UA_F2: begin
        w.nxt    = NX_DISP;
        w.pc_oe  = 1'b1;
        w.imm_oe = 1'b1;
        w.imm    = 4'd1;
        w.op     = ALU_ADD;
        w.cin    = CIN_ZERO;
        w.pc_we  = 1'b1;
      end
      UA_J1: begin
        w.nxt     = NX_STEP;
        w.rd      = 1'b1;
        w.mdr_we  = 1'b1;
        w.mdr_sel = 1'b1;
      end
      UA_J2: begin
        w.nxt    = NX_FETCH;
        w.mdr_oe = 1'b1;
        w.imm_oe = 1'b1;
        w.op     = ALU_ADD;
        w.cin    = CIN_ZERO;
        w.pc_we  = 1'b1;
      end
      default: w.nxt = NX_FETCH;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mcc_ucode_rom.sv
module mcc_ucode_rom
  import mcc_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output cw_t             word
);

  always_comb begin
    word = ucode_word(addr);
  end

endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
#(
  parameter logic [DW-1:0] JMP_OPC = 8'h20
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   ir,
  output logic [UA_W-1:0] upc,
  output cw_t             cw
);

  logic [UA_W-1:0] upc_q, upc_d, disp_ua;
  cw_t             cw_q, cw_d;

  // opcode to routine entry; unknown opcodes fall back to fetch
  always_comb begin
    if (ir == JMP_OPC) disp_ua = UA_JMP;
    else               disp_ua = UA_FETCH;
  end

  always_comb begin
    case (cw_q.nxt)
      NX_FETCH: upc_d = UA_FETCH;
      NX_DISP:  upc_d = disp_ua;
      default:  upc_d = upc_q + 1'b1;
    endcase
  end

  // look up the word of the next step so the control word is a flop output
  mcc_ucode_rom u_rom (
    .addr (upc_d),
    .word (cw_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q <= UA_FETCH;
      cw_q  <= ucode_word(UA_FETCH);
    end else begin
      upc_q <= upc_d;
      cw_q  <= cw_d;
    end
  end

  assign upc = upc_q;
  assign cw  = cw_q;

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_q.nxt == NX_STEP) |=> (upc_q == $past(upc_q) + 1'b1));

  a_r4_return: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_q.nxt == NX_FETCH) |=> (upc_q == UA_FETCH));

  a_r6_dispatch_jmp: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_q.nxt == NX_DISP && ir == JMP_OPC) |=> (upc_q == UA_JMP));

  a_r7_dispatch_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_q.nxt == NX_DISP && ir != JMP_OPC) |=> (upc_q == UA_FETCH));

  a_r8_rd_steps: assert property (@(posedge clk) disable iff (!rst_n)
    cw_q.rd |-> (upc_q == UA_F1 || upc_q == UA_J1));

endmodule

// File: rtl/mcc_datapath.sv
module mcc_datapath
  import mcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cw_t           cw,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mar,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] mdr
);

  logic [DW-1:0] pc_q, pc_d, mar_q, mar_d, ir_q, ir_d, mdr_q, mdr_d;
  logic [DW-1:0] a_bus, b_bus, alu_y;
  logic          cin;

  // adder operands
  always_comb begin
    if (cw.pc_oe)       a_bus = pc_q;
    else if (cw.mdr_oe) a_bus = mdr_q;
    else                a_bus = '0;
    b_bus = cw.imm_oe ? {{(DW-IMM_W){1'b0}}, cw.imm} : '0;
    cin   = (cw.cin == CIN_ONE);
  end

  always_comb begin
    if (cw.mode)              alu_y = a_bus & b_bus;
    else if (cw.op == ALU_ADD) alu_y = a_bus + b_bus + {{(DW-1){1'b0}}, cin};
    else                      alu_y = a_bus;
  end

  // next-state with explicit enables
  always_comb begin
    pc_d  = cw.pc_we  ? alu_y     : pc_q;
    mar_d = cw.mar_we ? alu_y     : mar_q;
    ir_d  = cw.ir_we  ? mem_rdata : ir_q;
    if (cw.mdr_we) mdr_d = cw.mdr_sel ? mem_rdata : alu_y;
    else           mdr_d = mdr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      ir_q  <= ir_d;
      mdr_q <= mdr_d;
    end
  end

  assign pc  = pc_q;
  assign mar = mar_q;
  assign ir  = ir_q;
  assign mdr = mdr_q;

  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.pc_we && cw.pc_oe && cw.imm_oe && cw.imm == 4'd1 && cw.op == ALU_ADD
     && !cw.mode && cw.cin == CIN_ZERO) |=> (pc_q == $past(pc_q) + 1'b1));

  a_r6_pc_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.pc_we && cw.mdr_oe && !cw.pc_oe && cw.imm_oe && cw.imm == '0
     && cw.op == ALU_ADD && !cw.mode && cw.cin == CIN_ZERO) |=> (pc_q == $past(mdr_q)));

  a_r8_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cw.ir_we |=> (ir_q == $past(mem_rdata)));

  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cw.pc_we |=> $stable(pc_q));

endmodule

// File: rtl/mcode_cpu_ctrl.sv
module mcode_cpu_ctrl
  import mcc_pkg::*;
#(
  parameter logic [DW-1:0] JMP_OPC = 8'h20
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            rom_sel,
  output logic            ram_sel,
  output logic [DW-1:0]   pc,
  output logic [UA_W-1:0] upc,
  output logic [CW_W-1:0] ctrl_word
);

  logic    rst_s1, rst_sync;
  cw_t     cw;
  logic [DW-1:0] mar, ir, mdr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  mcc_sequencer #(.JMP_OPC(JMP_OPC)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync),
    .ir    (ir),
    .upc   (upc),
    .cw    (cw)
  );

  mcc_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cw        (cw),
    .mem_rdata (mem_rdata),
    .mar       (mar),
    .pc        (pc),
    .ir        (ir),
    .mdr       (mdr)
  );

  assign mem_addr  = mar;
  assign mem_rd    = cw.rd;
  assign rom_sel   = ~mar[DW-1];
  assign ram_sel   = mar[DW-1];
  assign ctrl_word = cw;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst_n)
    1'b1 |=> (upc == '0 && pc == '0 && mem_addr == '0));

endmodule

// File: tb/mcode_cpu_ctrl_bench.sv
module mcode_cpu_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem [256];
  logic [7:0]  mem_rdata, mem_addr, pc;
  logic        mem_rd, rom_sel, ram_sel;
  logic [4:0]  upc;
  logic [31:0] ctrl_word;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  mcode_cpu_ctrl u_mcode_cpu_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .pc        (pc),
    .upc       (upc),
    .ctrl_word (ctrl_word)
  );

  int n_chk = 0;
  int n_bad = 0;
  int loops = 0;
  int m_upc;
  logic [7:0] m_pc, m_mar, m_ir, m_mdr;
  bit m_inc, m_unk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected control word from the R2 field positions
  function automatic logic [31:0] exp_cw(int u);
    logic [31:0] w;
    case (u)
      0, 27: w = (1 << 2) | (1 << 4) | (9 << 9) | (1 << 14) | (1 << 16);
      1:     w = (1 << 21) | (1 << 18);
      2:     w = 3 | (1 << 2) | (1 << 4) | (1 << 5) | (9 << 9) | (1 << 14) | (1 << 17);
      28:    w = (1 << 21) | (1 << 19) | (1 << 20);
      29:    w = 2 | (1 << 3) | (1 << 4) | (9 << 9) | (1 << 14) | (1 << 17);
      default: w = 2;
    endcase
    return w;
  endfunction

  task automatic compare(bit first);
    string t_upc, t_pc;
    t_upc = first ? "R1" : (m_unk ? "R7" : "R4");
    t_pc  = first ? "R1" : (m_inc ? "R5" : (m_upc >= 27 ? "R6" : "R3"));
    chk(t_upc, "upc", 32'(upc), 32'(m_upc));
    chk(t_pc, "pc", 32'(pc), 32'(m_pc));
    chk(first ? "R1" : "R3", "mem_addr", 32'(mem_addr), 32'(m_mar));
    chk("R8", "mem_rd", 32'(mem_rd), 32'((m_upc == 1 || m_upc == 28) ? 1 : 0));
    chk(first ? "R1" : "R2", "ctrl_word", ctrl_word, exp_cw(m_upc));
    chk("R9", "selects", 32'({rom_sel, ram_sel}), 32'({~m_mar[7], m_mar[7]}));
  endtask

  task automatic step();
    m_inc = 1'b0;
    m_unk = 1'b0;
    case (m_upc)
      0:  begin m_mar = m_pc; m_upc = 1; end
      1:  begin m_ir = mem[m_mar]; m_upc = 2; end
      2:  begin
            m_pc  = m_pc + 8'd1;
            m_inc = 1'b1;
            if (m_ir == 8'h20) m_upc = 27;
            else begin m_upc = 0; m_unk = 1'b1; end
          end
      27: begin m_mar = m_pc; m_upc = 28; end
      28: begin m_mdr = mem[m_mar]; m_upc = 29; end
      29: begin
            m_pc  = m_mdr;
            m_upc = 0;
            if (m_mdr == 8'h80) loops++;
          end
      default: m_upc = 0;
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_upc = 0; m_pc = 0; m_mar = 0; m_ir = 0; m_mdr = 0;
    m_inc = 1'b0; m_unk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(i == 0);
      step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    // R10: ping-pong between ROM and RAM
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    mem[8'h00] = 8'h20; mem[8'h01] = 8'h80;
    mem[8'h80] = 8'h20; mem[8'h81] = 8'h00;
    do_reset();
    loops = 0;
    run(1300);
    chk("R10", "loop count >= 100", 32'(loops >= 100), 32'd1);

    // R7: unknown opcodes step the PC, then a jump enters the loop
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    mem[8'h00] = 8'hFF; mem[8'h01] = 8'h07; mem[8'h02] = 8'h21;
    mem[8'h03] = 8'h20; mem[8'h04] = 8'h80;
    mem[8'h80] = 8'h20; mem[8'h81] = 8'h00;
    do_reset();
    run(120);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule